// File: doc/BRIEF.md
# SPI Flash Byte-Stream Bridge

This block lets a processor talk to serial flash devices with ordinary loads and stores. Each device has a small control register. It holds a mode, a chip-select release flag, a clock divider code and a lane setting. When a device is in pass-through mode with its release flag clear, its chip-select line is driven low. Every store to that device's window then shifts the stored bytes onto the serial bus, and every load returns bytes shifted in from the device. Software builds a whole flash command this way. It writes the opcode and address bytes, reads or writes the payload, and sets the release flag to end the command.

A window access stalls on `win_ready` until the last serial bit has moved. A word access moves four bytes, lowest byte first. The serial bus runs in clock-idle-low, sample-on-rise fashion. The block provides single-lane transfers and two dual-lane variants. An access to a device whose chip select is not driven finishes at once and returns all ones.

Top module: `spi_user_bridge`

## Requirements
- R1: After reset every control register reads 0x0000_0004 (mode 0, release flag set), all `cs_n` lines are high, `sck` is low and `win_ready` is low.
- R2: A control register keeps only mode at bits [1:0], the release flag at bit 2, the clock code at bits [11:8] and the lane code at bits [30:28]. All other bits read back as zero.
- R3: `cs_n[i]` is low exactly when device i has mode 3 and its release flag at 0. Any other mode, or a set flag, keeps it high.
- R4: An access to an index with `cs_n` high, or to an index of NUM_CS or more, gives `win_ready` in the cycle after acceptance. It returns 0xFFFF_FFFF and produces no `sck` edge.
- R5: A store on one lane drives `sdo[0]` with `sdo_oe`=01, most significant bit first. A word store sends byte 0 first and byte 3 last.
- R6: A load on one lane samples `sdi[1]` on each rising `sck`, most significant bit first. A byte load returns the byte in bits [7:0] with zeros above it. A word load puts the k-th received byte in bits [8k+7:8k].
- R7: Clock codes 15,7,14,6,13,5,12,4,11,3,10,2,9,1,8,0 select a divisor of 1 to 16 in that order. Each `sck` half period lasts divisor clock cycles. `win_ready` rises 2 x divisor x (number of `sck` pulses) cycles after the accepting edge.
- R8: Lane code 010 makes loads use two lanes, four `sck` pulses per byte, with `sdi[1]` carrying the higher bit of each pair and `sdo_oe`=00. Stores stay on one lane.
- R9: Lane code 011 makes loads dual as in R8. The first byte moved after chip select asserts is stored on one lane. Every later store byte uses two lanes with `sdo_oe`=11 and `sdo[1]` carrying the higher bit.
- R10: `win_ready` is high for one cycle per access. A request still held in that cycle is not accepted again.
- R11: A control-register write in a cycle where an access is in progress, or is being accepted, is discarded.
- R12: While an access is in progress, `sdo` changes only in the cycle where `sck` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_idx | input | IDX_W | Device index for register write and readback |
| cfg_wdata | input | 32 | Control register write data |
| cfg_rdata | output | 32 | Control register of device cfg_idx |
| win_req | input | 1 | Window access request, held until win_ready |
| win_we | input | 1 | 1 for a store, 0 for a load |
| win_word | input | 1 | 1 for a four-byte access, 0 for one byte |
| win_idx | input | IDX_W | Device whose window is accessed |
| win_wdata | input | 32 | Store data |
| win_rdata | output | 32 | Load data, valid with win_ready |
| win_ready | output | 1 | One-cycle completion pulse |
| sck | output | 1 | Serial clock |
| cs_n | output | NUM_CS | Active-low device selects |
| sdo | output | 2 | Serial data out, lane 1 and lane 0 |
| sdo_oe | output | 2 | Output enables for sdo lanes |
| sdi | input | 2 | Serial data in, lane 1 and lane 0 |

## Verification
A wrong internal state shows up at the ports quickly. A bad per-device session flag changes the number of `sck` pulses in the next dual-lane store. A bad divisor or beat count moves the `win_ready` pulse by whole half periods. A corrupted configuration shows up on `cs_n` in the very next cycle. The bench models the flash side from `sck`, `sdo` and `sdo_oe`, and compares every cycle's `cs_n` and idle `sck` against its own register model. For each access it also predicts the pulse count, the exact ready latency and the data bytes, so any miscount surfaces at the end of the access it occurs in.

// File: rtl/spi_user_bridge.sv
module spi_user_bridge #(
  parameter int NUM_CS = 3,
  parameter int IDX_W  = (NUM_CS > 1) ? $clog2(NUM_CS + 1) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              win_req,
  input  logic              win_we,
  input  logic              win_word,
  input  logic [IDX_W-1:0]  win_idx,
  input  logic [31:0]       win_wdata,
  output logic [31:0]       win_rdata,
  output logic              win_ready,
  output logic              sck,
  output logic [NUM_CS-1:0] cs_n,
  output logic [1:0]        sdo,
  output logic [1:0]        sdo_oe,
  input  logic [1:0]        sdi
);

  localparam logic [1:0] MODE_PASS = 2'd3;
  localparam logic [2:0] IO_DUAL_D = 3'b010;
  localparam logic [2:0] IO_DUAL_AD = 3'b011;

  logic [NUM_CS-1:0][1:0] mode_q;
  logic [NUM_CS-1:0]      stop_q;
  logic [NUM_CS-1:0][3:0] clk_q;
  logic [NUM_CS-1:0][2:0] io_q;
  logic [NUM_CS-1:0]      started_q;
  logic [NUM_CS-1:0]      act;

  logic             busy_q, ready_q, sck_q, we_q, dual_q;
  logic [3:0]       cnt_q;
  logic [2:0]       beat_q;
  logic [1:0]       bleft_q, bidx_q;
  logic [IDX_W-1:0] cur_q;
  logic [31:0]      wbuf_q, rdata_q;
  logic [7:0]       sr_q, in_q;

  function automatic logic [3:0] half_m1(input logic [3:0] c);
    logic [4:0] d;
    d = c[3] ? (5'd31 - {c, 1'b0}) : (5'd16 - {c, 1'b0});
    return 4'(d - 5'd1);
  endfunction

  function automatic logic dual_for(input logic [2:0] io, input logic we, input logic started);
    return we ? (io == IO_DUAL_AD && started) : (io == IO_DUAL_D || io == IO_DUAL_AD);
  endfunction

  for (genvar g = 0; g < NUM_CS; g++) begin : g_sel
    assign act[g] = (mode_q[g] == MODE_PASS) && !stop_q[g];
  end
  assign cs_n = ~act;

  wire idx_ok  = win_idx < IDX_W'(NUM_CS);
  wire sel_act = idx_ok && act[win_idx];
  wire acc     = win_req && !busy_q && !ready_q;
  wire cfg_ok  = cfg_we && !busy_q && !acc && (cfg_idx < IDX_W'(NUM_CS));
  wire acc_dual = dual_for(io_q[win_idx], win_we, started_q[win_idx]);
  wire nxt_dual = dual_for(io_q[cur_q], we_q, 1'b1);

  always_comb begin
    cfg_rdata = '0;
    if (cfg_idx < IDX_W'(NUM_CS))
      cfg_rdata = {1'b0, io_q[cfg_idx], 16'b0, clk_q[cfg_idx], 5'b0, stop_q[cfg_idx], mode_q[cfg_idx]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; stop_q <= '1; clk_q <= '0; io_q <= '0; started_q <= '0;
      busy_q <= 1'b0; ready_q <= 1'b0; sck_q <= 1'b0; we_q <= 1'b0; dual_q <= 1'b0;
      cnt_q <= '0; beat_q <= '0; bleft_q <= '0; bidx_q <= '0; cur_q <= '0;
      wbuf_q <= '0; rdata_q <= '0; sr_q <= '0; in_q <= '0;
    end else begin
      ready_q <= 1'b0;
      for (int i = 0; i < NUM_CS; i++)
        if (!act[i]) started_q[i] <= 1'b0;
      if (cfg_ok) begin
        mode_q[cfg_idx] <= cfg_wdata[1:0];
        stop_q[cfg_idx] <= cfg_wdata[2];
        clk_q[cfg_idx]  <= cfg_wdata[11:8];
        io_q[cfg_idx]   <= cfg_wdata[30:28];
      end
      if (acc) begin
        cur_q   <= win_idx;
        we_q    <= win_we;
        rdata_q <= sel_act ? '0 : '1;
        if (!sel_act) begin
          ready_q <= 1'b1;
        end else begin
          busy_q  <= 1'b1;
          wbuf_q  <= win_wdata;
          bleft_q <= win_word ? 2'd3 : 2'd0;
          bidx_q  <= '0;
          dual_q  <= acc_dual;
          beat_q  <= acc_dual ? 3'd3 : 3'd7;
          sr_q    <= win_we ? win_wdata[7:0] : 8'hFF;
          in_q    <= '0;
          sck_q   <= 1'b0;
          cnt_q   <= half_m1(clk_q[win_idx]);
        end
      end else if (busy_q) begin
        if (cnt_q != 4'd0) begin
          cnt_q <= cnt_q - 4'd1;
        end else begin
          cnt_q <= half_m1(clk_q[cur_q]);
          if (!sck_q) begin
            sck_q <= 1'b1;
            in_q  <= dual_q ? {in_q[5:0], sdi} : {in_q[6:0], sdi[1]};
          end else begin
            sck_q <= 1'b0;
            if (beat_q != 3'd0) begin
              beat_q <= beat_q - 3'd1;
              sr_q   <= dual_q ? {sr_q[5:0], 2'b00} : {sr_q[6:0], 1'b0};
            end else begin
              started_q[cur_q] <= 1'b1;
              if (!we_q) rdata_q[{bidx_q, 3'b000} +: 8] <= in_q;
              if (bleft_q != 2'd0) begin
                bleft_q <= bleft_q - 2'd1;
                bidx_q  <= bidx_q + 2'd1;
                wbuf_q  <= wbuf_q >> 8;
                sr_q    <= we_q ? wbuf_q[15:8] : 8'hFF;
                dual_q  <= nxt_dual;
                beat_q  <= nxt_dual ? 3'd3 : 3'd7;
              end else begin
                busy_q  <= 1'b0;
                ready_q <= 1'b1;
              end
            end
          end
        end
      end
    end
  end

  assign sck       = sck_q;
  assign win_ready = ready_q;
  assign win_rdata = rdata_q;
  assign sdo    = !busy_q ? 2'b00 : (dual_q && we_q) ? sr_q[7:6] : {1'b0, sr_q[7]};
  assign sdo_oe = !busy_q ? 2'b00 : dual_q ? (we_q ? 2'b11 : 2'b00) : 2'b01;

  assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> !ready_q);
  assert_idle_sck_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sck_q);
  assert_inactive_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !sel_act) |=> (ready_q && win_rdata == 32'hFFFF_FFFF && !busy_q));
  assert_cs_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !cs_n[cur_q]);
  assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> ($stable(mode_q) && $stable(stop_q) && $stable(clk_q) && $stable(io_q)));
  assert_mosi_on_fall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$fell(sck_q)) |-> $stable(sdo));
  assert_half_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != 4'd0) |=> $stable(sck_q));

endmodule

// File: tb/spi_user_bridge_test.sv
module spi_user_bridge_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0; logic [1:0] cfg_idx = '0; logic [31:0] cfg_wdata = '0; logic [31:0] cfg_rdata;
  logic win_req = 1'b0, win_we = 1'b0, win_word = 1'b0; logic [1:0] win_idx = '0;
  logic [31:0] win_wdata = '0, win_rdata; logic win_ready, sck;
  logic [2:0] cs_n; logic [1:0] sdo, sdo_oe, sdi;

  spi_user_bridge uut (.clk, .rst_n, .cfg_we, .cfg_idx, .cfg_wdata, .cfg_rdata,
    .win_req, .win_we, .win_word, .win_idx, .win_wdata, .win_rdata, .win_ready,
    .sck, .cs_n, .sdo, .sdo_oe, .sdi);

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, miscompares = 0, cycles = 0;
  bit done = 1'b0, in_access = 1'b0;
  int m_mode[3], m_clk[3], m_io[3]; bit m_stop[3], m_started[3];
  logic [31:0] resp = '0, cap = '0; int ptr = 0, edges = 0;

  function automatic logic bitat(input logic [31:0] r, input int p);
    if (p >= 32) return 1'b0;
    return r[8*(p/8) + 7 - (p%8)];
  endfunction
  assign sdi = {bitat(resp, ptr), bitat(resp, ptr + 1)};

  always @(posedge sck) begin
    if (sdo_oe == 2'b01) begin
      if (ptr < 32) cap[8*(ptr/8) + 7 - (ptr%8)] = sdo[0];
      ptr += 1;
    end else if (sdo_oe == 2'b11) begin
      if (ptr < 32) cap[8*(ptr/8) + 7 - (ptr%8)] = sdo[1];
      if (ptr + 1 < 32) cap[8*((ptr+1)/8) + 7 - ((ptr+1)%8)] = sdo[0];
      ptr += 2;
    end else ptr += 2;
    edges++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] actual, input logic [31:0] expected);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, actual, expected);
    end
  endtask

  function automatic bit m_act(input int i);
    return i < 3 && m_mode[i] == 3 && !m_stop[i];
  endfunction

  function automatic int divisor(input int code);
    int codes[16] = '{15,7,14,6,13,5,12,4,11,3,10,2,9,1,8,0};
    for (int i = 0; i < 16; i++) if (codes[i] == code) return i + 1;
    return 0;
  endfunction

  function automatic logic [31:0] m_reg(input int i);
    return {1'b0, 3'(m_io[i]), 16'b0, 4'(m_clk[i]), 5'b0, m_stop[i], 2'(m_mode[i])};
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [2:0] e;
      for (int i = 0; i < 3; i++) e[i] = !m_act(i);
      chk(cs_n == e, "R3 cs_n per cycle", 32'(cs_n), 32'(e));
      if (!in_access) chk(sck == 1'b0, "R4 sck idle", 32'(sck), 0);
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      finish_run();
    end
  end

  task automatic cfg_write(input int i, input logic [31:0] d, input bit upd);
    @(negedge clk); cfg_we = 1'b1; cfg_idx = 2'(i); cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
    if (upd) begin
      m_mode[i] = int'(d[1:0]); m_stop[i] = d[2]; m_clk[i] = int'(d[11:8]); m_io[i] = int'(d[30:28]);
      if (!m_act(i)) m_started[i] = 1'b0;
    end
  endtask

  task automatic cfg_check(input int i, input string req);
    @(negedge clk); cfg_idx = 2'(i); #1;
    chk(cfg_rdata == m_reg(i), req, cfg_rdata, m_reg(i));
  endtask

  task automatic xfer(input int idx, input bit we, input bit word, input logic [31:0] wd,
                      input logic [31:0] rs, input bit hold, input string req);
    bit a; int nb, exp_edges, lat, n; bit st; logic [31:0] rd, mask, exp_rd;
    a = m_act(idx); nb = word ? 4 : 1; exp_edges = 0; st = (idx < 3) ? m_started[idx] : 1'b0;
    if (a) for (int k = 0; k < nb; k++) begin
      bit d;
      d = we ? (m_io[idx] == 3 && (st || k > 0)) : (m_io[idx] == 2 || m_io[idx] == 3);
      exp_edges += d ? 4 : 8;
    end
    lat = a ? 2 * divisor(m_clk[idx]) * exp_edges + 1 : 1;
    @(negedge clk);
    resp = rs; cap = '0; ptr = 0; edges = 0; in_access = 1'b1;
    win_req = 1'b1; win_we = we; win_word = word; win_idx = 2'(idx); win_wdata = wd;
    n = 0;
    do begin @(negedge clk); n++; end while (!win_ready && n < 5000);
    rd = win_rdata;
    if (hold) begin
      @(negedge clk);
      chk(win_ready == 1'b0, {req, " R10 ready pulse"}, 32'(win_ready), 0);
    end
    win_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(win_ready == 1'b0 && edges == (a ? exp_edges : 0), {req, " R10 no re-accept"}, 32'(edges), 32'(a ? exp_edges : 0));
    in_access = 1'b0;
    chk(n == lat, {req, " R7 latency"}, 32'(n), 32'(lat));
    chk(edges == (a ? exp_edges : 0), {req, " R8/R9 sck pulses"}, 32'(edges), 32'(a ? exp_edges : 0));
    mask = word ? 32'hFFFF_FFFF : 32'h0000_00FF;
    if (!a) exp_rd = 32'hFFFF_FFFF;
    else if (we) exp_rd = 32'h0;
    else exp_rd = rs & mask;
    if (!we || !a) chk(rd == exp_rd, {req, " R6 rdata"}, rd, exp_rd);
    if (we && a) chk((cap & mask) == (wd & mask), {req, " R5 bytes on sdo"}, cap & mask, wd & mask);
    if (a) m_started[idx] = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin
      m_mode[i] = 0; m_stop[i] = 1'b1; m_clk[i] = 0; m_io[i] = 0; m_started[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 3'b111, "R1 cs_n reset", 32'(cs_n), 32'h7);
    chk(sck == 1'b0 && win_ready == 1'b0, "R1 sck/ready reset", {30'b0, sck, win_ready}, 0);
    for (int i = 0; i < 3; i++) cfg_check(i, "R1 reset register");

    xfer(0, 1'b1, 1'b0, 32'h55, 32'h0, 1'b0, "R4 deselected store");
    xfer(3, 1'b0, 1'b1, 32'h0, 32'h1234, 1'b0, "R4 out of range load");

    cfg_write(0, {1'b1, 3'b000, 16'hFFFF, 4'hF, 5'b11111, 1'b0, 2'b11}, 1'b1);
    cfg_check(0, "R2 field readback");
    cfg_write(1, 32'h0000_0F01, 1'b1);
    cfg_check(1, "R2 mode1 readback");
    xfer(1, 1'b0, 1'b0, 32'h0, 32'hAA, 1'b0, "R3 non-pass mode");

    xfer(0, 1'b1, 1'b0, 32'h9F, 32'h0, 1'b0, "R5 byte store");
    xfer(0, 1'b0, 1'b0, 32'h0, 32'hC2, 1'b0, "R6 byte load");
    xfer(0, 1'b1, 1'b1, 32'h1234_5678, 32'h0, 1'b0, "R5 word store");
    xfer(0, 1'b0, 1'b1, 32'h0, 32'hA5C3_0F81, 1'b0, "R6 word load");

    cfg_write(0, 32'h0000_0003, 1'b1);
    xfer(0, 1'b1, 1'b0, 32'h3C, 32'h0, 1'b0, "R7 code0 div16");
    cfg_write(0, 32'h0000_0703, 1'b1);
    xfer(0, 1'b0, 1'b0, 32'h0, 32'h6E, 1'b0, "R7 code7 div2");
    cfg_write(0, 32'h0000_0803, 1'b1);
    xfer(0, 1'b1, 1'b0, 32'hE1, 32'h0, 1'b0, "R7 code8 div15");

    cfg_write(0, 32'h2000_0F03, 1'b1);
    cfg_check(0, "R2 lane code readback");
    xfer(0, 1'b1, 1'b0, 32'h0B, 32'h0, 1'b0, "R8 dual-data store single");
    xfer(0, 1'b0, 1'b1, 32'h0, 32'hD2B4_7196, 1'b0, "R8 dual-data word load");

    cfg_write(0, 32'h3000_0F07, 1'b1);
    cfg_write(0, 32'h3000_0F03, 1'b1);
    xfer(0, 1'b1, 1'b1, 32'hC3A5_9E3B, 32'h0, 1'b0, "R9 first byte single then dual");
    xfer(0, 1'b0, 1'b0, 32'h0, 32'h4D, 1'b0, "R9 dual load");
    xfer(0, 1'b1, 1'b0, 32'h72, 32'h0, 1'b0, "R9 later store dual");

    cfg_write(2, 32'h0000_0F03, 1'b1);
    xfer(2, 1'b1, 1'b1, 32'h0F1E_2D3C, 32'h0, 1'b1, "R10 held request dev2");

    cfg_write(0, 32'h0000_0003, 1'b1);
    fork
      xfer(0, 1'b1, 1'b0, 32'h99, 32'h0, 1'b0, "R11 store during write");
      begin
        repeat (12) @(negedge clk);
        cfg_write(0, 32'h0000_0004, 1'b0);
      end
    join
    cfg_check(0, "R11 write ignored while busy");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule